// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus that a target holds low while it waits to drive an acknowledge. It does no bit-level signalling itself. It drives a byte-level I2C master engine through that engine's register interface. It issues control-register writes, status clears and data-register reads, and it polls status bits. The steps follow a fixed order with timed pauses between them. All pauses are counted in periods of a one-cycle microsecond tick input, so the schedule does not depend on the core clock frequency.

Two recovery flavours can be selected at start. The generic flavour repeats a start / repeated-start register pattern a fixed number of times, which gives nine SCL pulses, and then issues a STOP. The erratum flavour first starts a transfer and waits for bus-busy. It then checks arbitration-lost to decide whether SDA is stuck, and it takes one of two short completion paths. A status poll that gets no answer within its time limit ends the run with an error pulse.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After synchronous reset, busy_o, done_o, err_o and all three access strobes are low. While idle, no access strobe rises.
- R2: Each generic pass issues, one strobe per cycle, in this order: a control write of 0x00, a status clear, a control write of 0xA0, a data read, a pause of SETTLE_US ticks, a control write of 0xA4 and a data read. Control encoding: 0x80 enable, 0x20 master, 0x04 repeated start, 0x02 reserved bit.
- R3: Exactly PASSES passes run. Between passes there is a pause of GAP_US ticks. The last pass is followed directly by the stop tail, with no pause.
- R4: The stop tail is a control write of 0x80, a data read, a pause of SETTLE_US ticks and a control write of 0x00. done_o then pulses for one cycle, in the cycle after that final write.
- R5: The erratum flavour starts with a control write of 0xA0 and then polls status bit BUSY_BIT (default 5).
- R6: If status bit ARB_BIT (default 4) is set in the cycle where bus-busy is first seen, the block writes 0x00, 0x22 and 0xA2 and polls bus-busy again. It then reads data, polls status bit IF_BIT (default 1), writes 0x82 and pulses done_o. Arbitration-lost that rises later has no effect on the branch.
- R7: If arbitration-lost is clear when bus-busy is seen, the block reads data, polls IF_BIT, writes 0x80 and pulses done_o.
- R8: A poll that does not see its bit within POLL_US ticks aborts. err_o pulses for one cycle after the poll window, done_o stays low, and no further access is made.
- R9: A start request is accepted only while idle. A request during a run changes neither the access stream nor the selected flavour. busy_o is high from acceptance until the run ends.
- R10: done_o and err_o are never high together. When busy_o falls, exactly one of them pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go_i | input | 1 | Start request, sampled while idle |
| erratum_i | input | 1 | Flavour select at start: 1 erratum, 0 generic |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| sts_i | input | 8 | Live status byte of the master engine |
| ctl_wr_o | output | 1 | Control register write strobe |
| ctl_data_o | output | 8 | Control register write value |
| sts_clr_o | output | 1 | Status register clear strobe |
| dat_rd_o | output | 1 | Data register read strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle poll-timeout pulse |

## Verification
The bench uses the default parameters: nine passes, 15 and 5 tick pauses and a 100 tick poll limit. The tick runs at one pulse per four clocks, so a whole generic run and a full poll timeout both fit in short runs. This lets the bench measure the number of ticks between accesses exactly. It can therefore check every pause length, the missing gap after the last pass and the exact timeout length at both the bus-busy poll and the interrupt-flag poll. The status model can raise arbitration-lost together with bus-busy or after it, and this covers both erratum branches and the sampling rule that decides between them.

// File: rtl/unstick_pkg.sv
// Shared encodings for the bus recovery sequencer.
// Assumes the engine's control byte layout listed below.
package unstick_pkg;

    localparam logic [7:0] CTL_EN  = 8'h80;  // engine enable
    localparam logic [7:0] CTL_MS  = 8'h20;  // master mode / start
    localparam logic [7:0] CTL_RS  = 8'h04;  // repeated start
    localparam logic [7:0] CTL_RSV = 8'h02;  // reserved bit used by erratum path
    localparam logic [7:0] CTL_OFF = 8'h00;

    typedef enum logic [4:0] {
        ST_IDLE,
        G_CTL_OFF, G_STS_CLR, G_START, G_RD_A, G_SETTLE,
        G_RSTA, G_RD_B, G_GAP, G_STOP, G_RD_C, G_HOLD, G_OFF,
        E_START, E_POLL_BB, E_OFF, E_MSTA, E_MEN_MSTA, E_POLL_BB2,
        E_RD, E_POLL_IF, E_FIN
    } step_e;

endpackage

// File: rtl/unstick_timer.sv
// Microsecond interval timer.
// Counts tick pulses from zero after a clear; expired_o is high once the
// count equals the limit. Assumes the limit is held while counting.
module unstick_timer #(
    parameter int TW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic [TW-1:0] limit_i,
    output logic          expired_o
);

    logic [TW-1:0] cnt_q;

    // Tick counter, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else if (tick_i && (cnt_q < limit_i))
            cnt_q <= cnt_q + 1'b1;
    end

    // Expiry flag.
    always_comb expired_o = (cnt_q == limit_i);

endmodule

// File: rtl/unstick_fsm.sv
// Step sequencer for both recovery flavours.
// One engine access per step cycle; timed steps use the external timer,
// which is cleared on every step change. Assumes sts_i is live status.
module unstick_fsm import unstick_pkg::*; #(
    parameter int PASSES    = 9,
    parameter int SETTLE_US = 15,
    parameter int GAP_US    = 5,
    parameter int POLL_US   = 100,
    parameter int BUSY_BIT  = 5,
    parameter int ARB_BIT   = 4,
    parameter int IF_BIT    = 1,
    parameter int TW        = 7,
    parameter int PW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic          erratum_i,
    input  logic [7:0]    sts_i,
    input  logic          tmr_exp_i,
    output logic          tmr_clr_o,
    output logic [TW-1:0] tmr_lim_o,
    output logic          ctl_wr_o,
    output logic [7:0]    ctl_data_o,
    output logic          sts_clr_o,
    output logic          dat_rd_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);

    step_e         state_q, state_d;
    logic [PW-1:0] pass_q;
    logic          stuck_q;
    logic          done_q, err_q;
    logic          abort;
    logic          last_pass;
    logic          bb_seen, arb_seen, if_seen;

    always_comb begin
        last_pass = (pass_q == PW'(PASSES - 1));
        bb_seen   = sts_i[BUSY_BIT];
        arb_seen  = sts_i[ARB_BIT];
        if_seen   = sts_i[IF_BIT];
    end

    // Next-step selection and abort detection.
    always_comb begin
        state_d = state_q;
        abort   = 1'b0;
        unique case (state_q)
            ST_IDLE:    if (go_i) state_d = erratum_i ? E_START : G_CTL_OFF;
            G_CTL_OFF:  state_d = G_STS_CLR;
            G_STS_CLR:  state_d = G_START;
            G_START:    state_d = G_RD_A;
            G_RD_A:     state_d = G_SETTLE;
            G_SETTLE:   if (tmr_exp_i) state_d = G_RSTA;
            G_RSTA:     state_d = G_RD_B;
            G_RD_B:     state_d = last_pass ? G_STOP : G_GAP;
            G_GAP:      if (tmr_exp_i) state_d = G_CTL_OFF;
            G_STOP:     state_d = G_RD_C;
            G_RD_C:     state_d = G_HOLD;
            G_HOLD:     if (tmr_exp_i) state_d = G_OFF;
            G_OFF:      state_d = ST_IDLE;
            E_START:    state_d = E_POLL_BB;
            E_POLL_BB: begin
                if (bb_seen)
                    state_d = arb_seen ? E_OFF : E_RD;
                else if (tmr_exp_i) begin
                    abort   = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            E_OFF:      state_d = E_MSTA;
            E_MSTA:     state_d = E_MEN_MSTA;
            E_MEN_MSTA: state_d = E_POLL_BB2;
            E_POLL_BB2: begin
                if (bb_seen)
                    state_d = E_RD;
                else if (tmr_exp_i) begin
                    abort   = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            E_RD:       state_d = E_POLL_IF;
            E_POLL_IF: begin
                if (if_seen)
                    state_d = E_FIN;
                else if (tmr_exp_i) begin
                    abort   = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            E_FIN:      state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Timer control: restart on every step change, limit by step kind.
    always_comb begin
        tmr_clr_o = (state_d != state_q);
        unique case (state_q)
            G_SETTLE, G_HOLD:                  tmr_lim_o = TW'(SETTLE_US);
            G_GAP:                             tmr_lim_o = TW'(GAP_US);
            E_POLL_BB, E_POLL_BB2, E_POLL_IF:  tmr_lim_o = TW'(POLL_US);
            default:                           tmr_lim_o = '0;
        endcase
    end

    // Engine access decode, one strobe per access step.
    always_comb begin
        ctl_wr_o   = 1'b0;
        ctl_data_o = CTL_OFF;
        sts_clr_o  = 1'b0;
        dat_rd_o   = 1'b0;
        unique case (state_q)
            G_CTL_OFF, G_OFF, E_OFF: ctl_wr_o = 1'b1;
            G_STS_CLR:               sts_clr_o = 1'b1;
            G_START, E_START: begin
                ctl_wr_o   = 1'b1;
                ctl_data_o = CTL_EN | CTL_MS;
            end
            G_RSTA: begin
                ctl_wr_o   = 1'b1;
                ctl_data_o = CTL_EN | CTL_MS | CTL_RS;
            end
            G_STOP: begin
                ctl_wr_o   = 1'b1;
                ctl_data_o = CTL_EN;
            end
            E_MSTA: begin
                ctl_wr_o   = 1'b1;
                ctl_data_o = CTL_MS | CTL_RSV;
            end
            E_MEN_MSTA: begin
                ctl_wr_o   = 1'b1;
                ctl_data_o = CTL_EN | CTL_MS | CTL_RSV;
            end
            E_FIN: begin
                ctl_wr_o   = 1'b1;
                ctl_data_o = CTL_EN | (stuck_q ? CTL_RSV : CTL_OFF);
            end
            G_RD_A, G_RD_B, G_RD_C, E_RD: dat_rd_o = 1'b1;
            default: ;
        endcase
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Pass counter for the generic flavour.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pass_q <= '0;
        else if (state_q == ST_IDLE && go_i)
            pass_q <= '0;
        else if (state_q == G_GAP && tmr_exp_i)
            pass_q <= pass_q + 1'b1;
    end

    // Stuck-SDA verdict, taken when bus-busy is first seen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stuck_q <= 1'b0;
        else if (state_q == E_POLL_BB && bb_seen)
            stuck_q <= arb_seen;
    end

    // Completion and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= (state_q == G_OFF) || (state_q == E_FIN);
            err_q  <= abort;
        end
    end

    // Status outputs.
    always_comb begin
        busy_o = (state_q != ST_IDLE);
        done_o = done_q;
        err_o  = err_q;
    end

endmodule

// File: rtl/i2c_bus_unstick.sv
// Top of the bus recovery sequencer: step sequencer plus tick timer.
// Assumes us_tick_i is a single-cycle pulse and sts_i is the engine's
// live status byte.
module i2c_bus_unstick #(
    parameter int PASSES    = 9,
    parameter int SETTLE_US = 15,
    parameter int GAP_US    = 5,
    parameter int POLL_US   = 100,
    parameter int BUSY_BIT  = 5,
    parameter int ARB_BIT   = 4,
    parameter int IF_BIT    = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic       erratum_i,
    input  logic       us_tick_i,
    input  logic [7:0] sts_i,
    output logic       ctl_wr_o,
    output logic [7:0] ctl_data_o,
    output logic       sts_clr_o,
    output logic       dat_rd_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o
);

    localparam int TMAX_A = (SETTLE_US > GAP_US) ? SETTLE_US : GAP_US;
    localparam int TMAX   = (TMAX_A > POLL_US) ? TMAX_A : POLL_US;
    localparam int TW     = $clog2(TMAX + 1);
    localparam int PW     = (PASSES > 1) ? $clog2(PASSES) : 1;

    logic          tmr_clr;
    logic          tmr_exp;
    logic [TW-1:0] tmr_lim;

    unstick_fsm #(
        .PASSES(PASSES), .SETTLE_US(SETTLE_US), .GAP_US(GAP_US),
        .POLL_US(POLL_US), .BUSY_BIT(BUSY_BIT), .ARB_BIT(ARB_BIT),
        .IF_BIT(IF_BIT), .TW(TW), .PW(PW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go_i),
        .erratum_i  (erratum_i),
        .sts_i      (sts_i),
        .tmr_exp_i  (tmr_exp),
        .tmr_clr_o  (tmr_clr),
        .tmr_lim_o  (tmr_lim),
        .ctl_wr_o   (ctl_wr_o),
        .ctl_data_o (ctl_data_o),
        .sts_clr_o  (sts_clr_o),
        .dat_rd_o   (dat_rd_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    unstick_timer #(.TW(TW)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .tick_i    (us_tick_i),
        .limit_i   (tmr_lim),
        .expired_o (tmr_exp)
    );

endmodule

// File: rtl/i2c_bus_unstick_chk.sv
// Protocol checker for the recovery sequencer, bound to the top.
// Observes ports only.
module i2c_bus_unstick_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr_o,
    input logic [7:0] ctl_data_o,
    input logic       sts_clr_o,
    input logic       dat_rd_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o
);

    // R1: no access while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(ctl_wr_o || sts_clr_o || dat_rd_o));

    // R2: at most one engine access per cycle
    a_r2_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_wr_o, sts_clr_o, dat_rd_o}));

    // R4: done follows directly on a control write
    a_r4_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(ctl_wr_o));

    // R6: the stuck-path final write ends the run
    a_r6_final_write_done: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_o && ctl_data_o == 8'h82) |=> done_o);

    // R8: error pulse comes with no access and no busy
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !(busy_o || ctl_wr_o || dat_rd_o || sts_clr_o));

    // R10: completion and error are exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    // R10: every end of a run is marked
    a_r10_end_marked: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o || err_o));

endmodule

bind i2c_bus_unstick i2c_bus_unstick_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr_o   (ctl_wr_o),
    .ctl_data_o (ctl_data_o),
    .sts_clr_o  (sts_clr_o),
    .dat_rd_o   (dat_rd_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/test_i2c_bus_unstick.sv
// Scoreboard bench: driver tasks queue expected accesses with the tick
// count since the previous access; the monitor compares them as they occur.
module test_i2c_bus_unstick;

    localparam int K_CTL = 0, K_CLR = 1, K_RD = 2, K_DONE = 3, K_ERR = 4;
    localparam int ANY   = 255;
    localparam logic [7:0] S_BB = 8'h20, S_ARB = 8'h10, S_IF = 8'h02;

    typedef struct {
        int         kind;
        logic [7:0] data;
        int         ticks;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go_i = 1'b0;
    logic       erratum_i = 1'b0;
    logic       us_tick_i = 1'b0;
    logic [7:0] sts_i = 8'h00;
    logic       ctl_wr_o, sts_clr_o, dat_rd_o, busy_o, done_o, err_o;
    logic [7:0] ctl_data_o;

    int    checks = 0;
    int    errors = 0;
    item_t q[$];
    int    tdiv = 0;
    int    tacc = 0;

    always #10 clk = ~clk;

    i2c_bus_unstick i_i2c_bus_unstick (
        .clk(clk), .rst_n(rst_n), .go_i(go_i), .erratum_i(erratum_i),
        .us_tick_i(us_tick_i), .sts_i(sts_i), .ctl_wr_o(ctl_wr_o),
        .ctl_data_o(ctl_data_o), .sts_clr_o(sts_clr_o), .dat_rd_o(dat_rd_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic expect_ev(input int kind, input logic [7:0] data,
                             input int ticks, input string req);
        item_t it;
        it.kind = kind; it.data = data; it.ticks = ticks; it.req = req;
        q.push_back(it);
    endtask

    task automatic observe(input int kind, input logic [7:0] data, input int ticks);
        item_t it;
        checks++;
        if (q.size() == 0) begin
            errors++;
            $display("FAIL R9 unexpected access kind %0d data %02h (expected none)", kind, data);
        end else begin
            it = q.pop_front();
            if (it.kind != kind || it.data != data ||
                (it.ticks != ANY && it.ticks != ticks)) begin
                errors++;
                $display("FAIL %s got kind %0d data %02h ticks %0d expected kind %0d data %02h ticks %0d",
                         it.req, kind, data, ticks, it.kind, it.data, it.ticks);
            end
        end
    endtask

    // Monitor: drive the tick for the coming cycle, then log accesses.
    always @(negedge clk) begin
        logic nt;
        logic ev;
        nt   = (tdiv == 3);
        tdiv = (tdiv + 1) % 4;
        us_tick_i <= nt;
        ev = 1'b0;
        if (rst_n) begin
            if (ctl_wr_o)  begin observe(K_CTL, ctl_data_o, tacc); tacc = 0; ev = 1'b1; end
            if (sts_clr_o) begin observe(K_CLR, 8'h00, tacc); tacc = 0; ev = 1'b1; end
            if (dat_rd_o)  begin observe(K_RD, 8'h00, tacc); tacc = 0; ev = 1'b1; end
            if (done_o)    begin observe(K_DONE, 8'h00, tacc); tacc = 0; ev = 1'b1; end
            if (err_o)     begin observe(K_ERR, 8'h00, tacc); tacc = 0; ev = 1'b1; end
            if (!ev && nt) tacc++;
        end
    end

    task automatic check(input logic cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic kick(input logic mode);
        @(negedge clk);
        go_i = 1'b1; erratum_i = mode;
        @(negedge clk);
        go_i = 1'b0;
    endtask

    task automatic drain(input string req);
        int n;
        n = 0;
        while (q.size() != 0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (40) @(negedge clk);
        check(q.size() == 0, req, q.size(), 0);
        q.delete();
    endtask

    task automatic wait_rd;
        int n;
        n = 0;
        do begin @(negedge clk); n++; end while (!dat_rd_o && n < 5000);
    endtask

    task automatic run_generic;
        for (int p = 0; p < 9; p++) begin
            expect_ev(K_CTL, 8'h00, (p == 0) ? ANY : 5, "R3");
            expect_ev(K_CLR, 8'h00, 0, "R2");
            expect_ev(K_CTL, 8'hA0, 0, "R2");
            expect_ev(K_RD,  8'h00, 0, "R2");
            expect_ev(K_CTL, 8'hA4, 15, "R2");
            expect_ev(K_RD,  8'h00, 0, "R2");
        end
        expect_ev(K_CTL, 8'h80, 0, "R3");
        expect_ev(K_RD,  8'h00, 0, "R4");
        expect_ev(K_CTL, 8'h00, 15, "R4");
        expect_ev(K_DONE, 8'h00, 0, "R4");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !ctl_wr_o && !dat_rd_o && !sts_clr_o && !done_o && !err_o,
              "R1 reset outputs", busy_o, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!busy_o && !ctl_wr_o, "R1 idle after reset", busy_o, 0);

        // Generic flavour with a second start request mid-run (R9).
        run_generic();
        kick(1'b0);
        repeat (30) @(negedge clk);
        check(busy_o, "R9 busy during run", busy_o, 1);
        kick(1'b1);
        drain("R2 generic run complete");

        // Erratum, stuck SDA: arbitration-lost with bus-busy (R6).
        expect_ev(K_CTL, 8'hA0, ANY, "R5");
        expect_ev(K_CTL, 8'h00, ANY, "R6");
        expect_ev(K_CTL, 8'h22, 0, "R6");
        expect_ev(K_CTL, 8'hA2, 0, "R6");
        expect_ev(K_RD,  8'h00, ANY, "R6");
        expect_ev(K_CTL, 8'h82, ANY, "R6");
        expect_ev(K_DONE, 8'h00, 0, "R6");
        kick(1'b1);
        repeat (20) @(negedge clk);
        sts_i = S_BB | S_ARB;
        wait_rd();
        repeat (12) @(negedge clk);
        sts_i = S_BB | S_ARB | S_IF;
        drain("R6 stuck branch complete");
        sts_i = 8'h00;

        // Erratum, clear SDA; arbitration-lost rises only later (R7, R6).
        expect_ev(K_CTL, 8'hA0, ANY, "R5");
        expect_ev(K_RD,  8'h00, ANY, "R7");
        expect_ev(K_CTL, 8'h80, ANY, "R7");
        expect_ev(K_DONE, 8'h00, 0, "R7");
        kick(1'b1);
        repeat (15) @(negedge clk);
        sts_i = S_BB;
        repeat (3) @(negedge clk);
        sts_i = S_BB | S_ARB;
        repeat (10) @(negedge clk);
        sts_i = S_BB | S_ARB | S_IF;
        drain("R7 clear branch complete");
        sts_i = 8'h00;

        // Bus-busy never seen: timeout (R8).
        expect_ev(K_CTL, 8'hA0, ANY, "R5");
        expect_ev(K_ERR, 8'h00, 100, "R8");
        kick(1'b1);
        repeat (30) @(negedge clk);
        check(busy_o, "R8 busy while polling", busy_o, 1);
        drain("R8 bus-busy timeout");
        check(!busy_o && !done_o, "R8 idle after abort", busy_o, 0);

        // Interrupt flag never seen: timeout (R8).
        expect_ev(K_CTL, 8'hA0, ANY, "R5");
        expect_ev(K_RD,  8'h00, ANY, "R7");
        expect_ev(K_ERR, 8'h00, 100, "R8");
        sts_i = S_BB;
        kick(1'b1);
        drain("R8 flag timeout");
        sts_i = 8'h00;

        // Generic again after an error, to confirm clean restart (R3, R10).
        run_generic();
        kick(1'b0);
        drain("R10 restart after error");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule